// File: doc/BRIEF.md
# Serial Command Decoder with Automatic Transmit Power Sequencing

This block is the serial front end of a small FSK transmitter controller. A host drives a four-wire SPI link (clock, active-low select, data in, data out). The block samples these pins with the system clock. It shifts in command words MSB first and decides the meaning of each word from its leading bits. A finished command updates one group of configuration fields: band, output-clock divider, crystal load code, modulation polarity, deviation, carrier frequency word, bit rate, power reduction, battery threshold, wake-up timer and the power enables.

Two commands do more than write a register. The one-byte transmit command turns on the oscillator, synthesizer and power amplifier when automatic control is enabled. It then turns the rest of the frame into a raw bit stream for the modulator, and the stream ends when select goes high. The sleep command turns off the amplifier and synthesizer at once. It keeps the oscillator running for a programmable number of output-clock periods, which arrive as strobes on `mcuClkTick`. A read command made of zero bits sends a status word back on the data-out pin.

Top module: `spiCmdTop`

## Requirements
- R1: After reset the fields hold band 0, divider 0, load code 8, polarity 0, deviation 0, frequency 7D0h, rate 0, power reduction 0, battery field 00h, wake exponent 0 and mantissa 0, and all power enables 0. Because its disable bit is 0, the clock output enable is 1.
- R2: A 16-bit frame whose first three bits are 100 loads the band from bits 12:11, the divider from 10:8, the load code from 7:4, the polarity from bit 3 and the deviation from 2:0.
- R3: A 16-bit frame starting 1010 loads bits 11:0 into the frequency word. A 16-bit frame with upper byte C8h loads its low byte into the rate.
- R4: An 8-bit frame of the form 10110ppp loads ppp into the power reduction code.
- R5: A 16-bit frame with upper byte C0h loads the power flags. Bit 7 is auto oscillator/synthesizer and bit 6 is auto amplifier. Bits 5..1 are the direct enables for oscillator, synthesizer, amplifier, battery detect and wake timer. Bit 0 disables the clock output. Each enable output is the OR of its direct bit and its automatic state.
- R6: Upper byte C2h loads the battery threshold from bits 4:0, bit sync from bit 5 and calibration disable from bit 7. A frame starting 111 loads the wake exponent from bits 12:8 and the mantissa from bits 7:0.
- R7: A command takes effect only when select rises, and only if the bit count is exactly 16 (or 8 for the power frame). A frame of any other length, or one with an unknown prefix, changes nothing.
- R8: When the first 8 bits are C6h, the automatic enables are raised while select is still low. Bit 7 of the flags raises the oscillator and synthesizer, and bit 6 raises the amplifier.
- R9: After C6h, each further bit comes out on `txData` with a one-cycle `txValid` and changes no register, until select goes high.
- R10: Upper byte C4h with count S clears the automatic amplifier and synthesizer at once. It clears the automatic oscillator on the S-th tick, or at once when S is 0.
- R11: If a transmit command is decoded in the same cycle as the tick that would end a sleep countdown, the oscillator stays on and the countdown is dropped.
- R12: When the first 8 bits are all zero, `spiMiso` presents the status word MSB first. Bit 15 is valid before the 9th rising clock, and the word shifts on each later rising clock. Once select has been high for a few cycles, `spiMiso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| spiSck | input | 1 | Serial clock from host |
| spiCsN | input | 1 | Active-low select |
| spiMosi | input | 1 | Serial data in |
| spiMiso | output | 1 | Serial status data out |
| statusWord | input | 16 | Status value to return on a read |
| mcuClkTick | input | 1 | One strobe per output-clock period |
| bandSel | output | 2 | Band code |
| clkDivSel | output | 3 | Output clock divider code |
| loadCapSel | output | 4 | Crystal load code |
| modInvert | output | 1 | Modulation polarity |
| devSel | output | 3 | Deviation code |
| freqWord | output | 12 | Carrier frequency word |
| rateWord | output | 8 | Bit rate value |
| powerReduce | output | 3 | Power reduction code |
| batThresh | output | 5 | Battery threshold code |
| bitSyncEn | output | 1 | Transmit bit sync enable |
| wakeCalDis | output | 1 | Wake timer calibration disable |
| wakeExp | output | 5 | Wake timer exponent |
| wakeMant | output | 8 | Wake timer mantissa |
| oscEn | output | 1 | Oscillator enable |
| synthEn | output | 1 | Synthesizer enable |
| paEn | output | 1 | Power amplifier enable |
| batDetEn | output | 1 | Battery detector enable |
| wakeEn | output | 1 | Wake timer enable |
| clkOutEn | output | 1 | Clock output enable |
| streaming | output | 1 | Raw transmit stream active |
| txData | output | 1 | Streamed data bit |
| txValid | output | 1 | Streamed bit strobe |

## Verification
The sleep countdown and the transmit decoder can act in the same cycle. The tick that ends a one-period countdown lands exactly on the cycle in which the 8th bit of a C6h frame is decoded. The bench provokes this by timing its tick pulse from the serial clock edge, counting the synchronizer stages. It judges the result at the pins: the oscillator enable must stay high, and later ticks must not drop it. As a contrast, it also runs the same countdown with no transmit, where the oscillator is expected to turn off.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;
  localparam int CMD_W   = 16;
  localparam int SHORT_W = 8;
  localparam int FREQ_W  = 12;
  localparam int SLEEP_W = 8;

  localparam logic [7:0] TX_OP    = 8'hC6;
  localparam logic [7:0] PWR_OP   = 8'hC0;
  localparam logic [7:0] BAT_OP   = 8'hC2;
  localparam logic [7:0] SLEEP_OP = 8'hC4;
  localparam logic [7:0] RATE_OP  = 8'hC8;

  localparam logic [15:0] CFG_RST  = 16'h8080;
  localparam logic [15:0] PM_RST   = 16'hC000;
  localparam logic [15:0] FREQ_RST = 16'hA7D0;
  localparam logic [15:0] RATE_RST = 16'hC800;
  localparam logic [7:0]  POW_RST  = 8'hB0;
  localparam logic [15:0] BAT_RST  = 16'hC200;
  localparam logic [15:0] WAKE_RST = 16'hE000;

  typedef struct packed {
    logic wrCfg;
    logic wrPwrMgmt;
    logic wrFreq;
    logic wrRate;
    logic wrPower;
    logic wrBat;
    logic wrSleep;
    logic wrWake;
    logic txStart;
    logic streamBit;
    logic streamData;
    logic [CMD_W-1:0] data;
  } cmdStrobeT;
endpackage

// File: rtl/spiCmdCtrl.sv
module spiCmdCtrl
  import spiCmdPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      spiSck,
  input  logic      spiCsN,
  input  logic      spiMosi,
  input  logic [CMD_W-1:0] statusWord,
  output cmdStrobeT stb,
  output logic      streaming,
  output logic      spiMiso
);
  localparam int CNT_W = $clog2(CMD_W * 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);

  logic [SYNC_STAGES:0]   sckPipe;
  logic [SYNC_STAGES:0]   csPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe  <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sckPipe  <= {sckPipe[SYNC_STAGES-1:0], spiSck};
      csPipe   <= {csPipe[SYNC_STAGES-1:0], spiCsN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], spiMosi};
    end
  end

  logic sckRise, csRise, selected, mosiBit;
  assign sckRise  = sckPipe[SYNC_STAGES-1] & ~sckPipe[SYNC_STAGES];
  assign csRise   = csPipe[SYNC_STAGES-1] & ~csPipe[SYNC_STAGES];
  assign selected = ~csPipe[SYNC_STAGES-1];
  assign mosiBit  = mosiPipe[SYNC_STAGES-1];

  logic [CMD_W-1:0] shiftReg;
  logic [CMD_W-1:0] statusSh;
  logic [CNT_W-1:0] bitCnt;
  logic             readActive;

  logic [CMD_W-1:0] shiftNext;
  logic             atByteEdge, isTxCmd, isReadCmd, bitTaken;
  assign shiftNext  = {shiftReg[CMD_W-2:0], mosiBit};
  assign bitTaken   = sckRise & selected & ~streaming;
  assign atByteEdge = bitTaken & (bitCnt == LEN_SHORT - 1'b1);
  assign isTxCmd    = atByteEdge & (shiftNext[SHORT_W-1:0] == TX_OP);
  assign isReadCmd  = atByteEdge & (shiftNext[SHORT_W-1:0] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      statusSh   <= '0;
      bitCnt     <= '0;
      streaming  <= 1'b0;
      readActive <= 1'b0;
    end else if (!selected) begin
      bitCnt     <= '0;
      streaming  <= 1'b0;
      readActive <= 1'b0;
    end else if (bitTaken) begin
      shiftReg <= shiftNext;
      if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
      if (isTxCmd) streaming <= 1'b1;
      if (isReadCmd) begin
        readActive <= 1'b1;
        statusSh   <= statusWord;
      end else if (readActive) begin
        statusSh <= {statusSh[CMD_W-2:0], 1'b0};
      end
    end
  end

  assign spiMiso = readActive & statusSh[CMD_W-1];

  always_comb begin
    stb            = '0;
    stb.data       = shiftReg;
    stb.txStart    = isTxCmd;
    stb.streamBit  = sckRise & selected & streaming;
    stb.streamData = mosiBit;
    if (csRise && !streaming) begin
      if (bitCnt == LEN_LONG) begin
        casez (shiftReg[CMD_W-1 -: 8])
          8'b100?_????: stb.wrCfg     = 1'b1;
          8'b1010_????: stb.wrFreq    = 1'b1;
          8'b111?_????: stb.wrWake    = 1'b1;
          PWR_OP:       stb.wrPwrMgmt = 1'b1;
          BAT_OP:       stb.wrBat     = 1'b1;
          SLEEP_OP:     stb.wrSleep   = 1'b1;
          RATE_OP:      stb.wrRate    = 1'b1;
          default:      ;
        endcase
      end else if (bitCnt == LEN_SHORT && shiftReg[SHORT_W-1:3] == 5'b10110) begin
        stb.wrPower = 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiCmdRegs.sv
module spiCmdRegs
  import spiCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobeT         stb,
  input  logic              mcuClkTick,
  output logic [1:0]        bandSel,
  output logic [2:0]        clkDivSel,
  output logic [3:0]        loadCapSel,
  output logic              modInvert,
  output logic [2:0]        devSel,
  output logic [FREQ_W-1:0] freqWord,
  output logic [7:0]        rateWord,
  output logic [2:0]        powerReduce,
  output logic [4:0]        batThresh,
  output logic              bitSyncEn,
  output logic              wakeCalDis,
  output logic [4:0]        wakeExp,
  output logic [7:0]        wakeMant,
  output logic              oscEn,
  output logic              synthEn,
  output logic              paEn,
  output logic              batDetEn,
  output logic              wakeEn,
  output logic              clkOutEn,
  output logic              txData,
  output logic              txValid
);
  logic [7:0]         pmFlags;
  logic               autoOsc, autoSynth, autoPa;
  logic               sleepPending;
  logic [SLEEP_W-1:0] sleepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bandSel     <= CFG_RST[12:11];
      clkDivSel   <= CFG_RST[10:8];
      loadCapSel  <= CFG_RST[7:4];
      modInvert   <= CFG_RST[3];
      devSel      <= CFG_RST[2:0];
      pmFlags     <= PM_RST[7:0];
      freqWord    <= FREQ_RST[FREQ_W-1:0];
      rateWord    <= RATE_RST[7:0];
      powerReduce <= POW_RST[2:0];
      batThresh   <= BAT_RST[4:0];
      bitSyncEn   <= BAT_RST[5];
      wakeCalDis  <= BAT_RST[7];
      wakeExp     <= WAKE_RST[12:8];
      wakeMant    <= WAKE_RST[7:0];
    end else begin
      if (stb.wrCfg) begin
        bandSel    <= stb.data[12:11];
        clkDivSel  <= stb.data[10:8];
        loadCapSel <= stb.data[7:4];
        modInvert  <= stb.data[3];
        devSel     <= stb.data[2:0];
      end
      if (stb.wrPwrMgmt) pmFlags  <= stb.data[7:0];
      if (stb.wrFreq)    freqWord <= stb.data[FREQ_W-1:0];
      if (stb.wrRate)    rateWord <= stb.data[7:0];
      if (stb.wrPower)   powerReduce <= stb.data[2:0];
      if (stb.wrBat) begin
        batThresh  <= stb.data[4:0];
        bitSyncEn  <= stb.data[5];
        wakeCalDis <= stb.data[7];
      end
      if (stb.wrWake) begin
        wakeExp  <= stb.data[12:8];
        wakeMant <= stb.data[7:0];
      end
    end
  end

  // automatic enable sequencing: transmit beats sleep, sleep beats a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoOsc      <= 1'b0;
      autoSynth    <= 1'b0;
      autoPa       <= 1'b0;
      sleepPending <= 1'b0;
      sleepCnt     <= '0;
    end else if (stb.txStart) begin
      autoOsc      <= autoOsc | pmFlags[7];
      autoSynth    <= autoSynth | pmFlags[7];
      autoPa       <= autoPa | pmFlags[6];
      sleepPending <= 1'b0;
    end else if (stb.wrSleep) begin
      autoSynth <= 1'b0;
      autoPa    <= 1'b0;
      if (stb.data[SLEEP_W-1:0] == '0) begin
        autoOsc      <= 1'b0;
        sleepPending <= 1'b0;
      end else begin
        sleepPending <= 1'b1;
        sleepCnt     <= stb.data[SLEEP_W-1:0];
      end
    end else if (sleepPending && mcuClkTick) begin
      if (sleepCnt == SLEEP_W'(1)) begin
        autoOsc      <= 1'b0;
        sleepPending <= 1'b0;
      end else begin
        sleepCnt <= sleepCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txData  <= 1'b0;
    end else begin
      txValid <= stb.streamBit;
      if (stb.streamBit) txData <= stb.streamData;
    end
  end

  assign oscEn    = pmFlags[5] | autoOsc;
  assign synthEn  = pmFlags[4] | autoSynth;
  assign paEn     = pmFlags[3] | autoPa;
  assign batDetEn = pmFlags[2];
  assign wakeEn   = pmFlags[1];
  assign clkOutEn = ~pmFlags[0];
endmodule

// File: rtl/spiCmdTop.sv
module spiCmdTop
  import spiCmdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiSck,
  input  logic        spiCsN,
  input  logic        spiMosi,
  output logic        spiMiso,
  input  logic [15:0] statusWord,
  input  logic        mcuClkTick,
  output logic [1:0]  bandSel,
  output logic [2:0]  clkDivSel,
  output logic [3:0]  loadCapSel,
  output logic        modInvert,
  output logic [2:0]  devSel,
  output logic [11:0] freqWord,
  output logic [7:0]  rateWord,
  output logic [2:0]  powerReduce,
  output logic [4:0]  batThresh,
  output logic        bitSyncEn,
  output logic        wakeCalDis,
  output logic [4:0]  wakeExp,
  output logic [7:0]  wakeMant,
  output logic        oscEn,
  output logic        synthEn,
  output logic        paEn,
  output logic        batDetEn,
  output logic        wakeEn,
  output logic        clkOutEn,
  output logic        streaming,
  output logic        txData,
  output logic        txValid
);
  cmdStrobeT cmdStb;

  spiCmdCtrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .statusWord(statusWord), .stb(cmdStb),
    .streaming(streaming), .spiMiso(spiMiso)
  );

  spiCmdRegs u_regs (
    .clk(clk), .rstN(rstN), .stb(cmdStb), .mcuClkTick(mcuClkTick),
    .bandSel(bandSel), .clkDivSel(clkDivSel), .loadCapSel(loadCapSel),
    .modInvert(modInvert), .devSel(devSel), .freqWord(freqWord),
    .rateWord(rateWord), .powerReduce(powerReduce), .batThresh(batThresh),
    .bitSyncEn(bitSyncEn), .wakeCalDis(wakeCalDis), .wakeExp(wakeExp),
    .wakeMant(wakeMant), .oscEn(oscEn), .synthEn(synthEn), .paEn(paEn),
    .batDetEn(batDetEn), .wakeEn(wakeEn), .clkOutEn(clkOutEn),
    .txData(txData), .txValid(txValid)
  );
endmodule

// File: rtl/spiCmdChecker.sv
module spiCmdChecker
  import spiCmdPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        spiCsN,
  input logic        spiMiso,
  input cmdStrobeT   stb,
  input logic        streaming,
  input logic        txValid,
  input logic        oscEn,
  input logic        paEn,
  input logic [11:0] freqWord
);
  // R9: a stream strobe only follows a cycle in streaming mode
  a_r9_valid_needs_stream: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(streaming));

  // R9: each streamed bit is a single-cycle strobe
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> !txValid);

  // R8: the oscillator only turns on from a transmit or a flag write
  a_r8_osc_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscEn) |-> $past(stb.txStart || stb.wrPwrMgmt));

  // R10: the amplifier only drops after a sleep or a flag write
  a_r10_pa_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(paEn) |-> $past(stb.wrSleep || stb.wrPwrMgmt));

  // R7: the frequency word changes only on a committed frequency write
  a_r7_freq_only_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqWord) |-> $past(stb.wrFreq));

  // R12: data out is quiet once select has stayed high
  a_r12_miso_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(spiCsN, 1) && $past(spiCsN, 2) && $past(spiCsN, 3) && $past(spiCsN, 4))
      |-> !spiMiso);
endmodule

bind spiCmdTop spiCmdChecker u_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiMiso(spiMiso),
  .stb(cmdStb), .streaming(streaming), .txValid(txValid),
  .oscEn(oscEn), .paEn(paEn), .freqWord(freqWord)
);

// File: tb/spiCmdTop_tb.sv
module spiCmdTop_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, spiSck, spiCsN, spiMosi, spiMiso, mcuClkTick;
  logic [15:0] statusWord;
  logic [1:0] bandSel; logic [2:0] clkDivSel; logic [3:0] loadCapSel;
  logic modInvert; logic [2:0] devSel; logic [11:0] freqWord;
  logic [7:0] rateWord; logic [2:0] powerReduce; logic [4:0] batThresh;
  logic bitSyncEn, wakeCalDis; logic [4:0] wakeExp; logic [7:0] wakeMant;
  logic oscEn, synthEn, paEn, batDetEn, wakeEn, clkOutEn;
  logic streaming, txData, txValid;

  spiCmdTop u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // expected state
  logic [1:0] eBand; logic [2:0] eClk; logic [3:0] eCap; logic eMod; logic [2:0] eDev;
  logic [11:0] eFreq; logic [7:0] eRate; logic [2:0] ePow; logic [7:0] eBat;
  logic [4:0] eWExp; logic [7:0] eWMant; logic [7:0] ePm;
  logic eAutoOsc, eAutoSyn, eAutoPa;

  logic [31:0] capBits; int capCnt;
  always @(negedge clk) if (txValid) begin
    capBits = {capBits[30:0], txData};
    capCnt++;
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "band", 16'(bandSel), 16'(eBand));
    chk(req, "clkdiv", 16'(clkDivSel), 16'(eClk));
    chk(req, "loadcap", 16'(loadCapSel), 16'(eCap));
    chk(req, "polarity", 16'(modInvert), 16'(eMod));
    chk(req, "deviation", 16'(devSel), 16'(eDev));
    chk(req, "freq", 16'(freqWord), 16'(eFreq));
    chk(req, "rate", 16'(rateWord), 16'(eRate));
    chk(req, "power", 16'(powerReduce), 16'(ePow));
    chk(req, "batthresh", 16'(batThresh), 16'(eBat[4:0]));
    chk(req, "bitsync", 16'(bitSyncEn), 16'(eBat[5]));
    chk(req, "caldis", 16'(wakeCalDis), 16'(eBat[7]));
    chk(req, "wakeexp", 16'(wakeExp), 16'(eWExp));
    chk(req, "wakemant", 16'(wakeMant), 16'(eWMant));
    chk(req, "enables", {10'd0, oscEn, synthEn, paEn, batDetEn, wakeEn, clkOutEn},
        {10'd0, ePm[5] | eAutoOsc, ePm[4] | eAutoSyn, ePm[3] | eAutoPa, ePm[2], ePm[1], ~ePm[0]});
  endtask

  // model of a committed frame per R2..R7, R10
  task automatic model(input logic [31:0] bits, input int n);
    logic [15:0] c;
    c = bits[15:0];
    if (n == 16) begin
      casez (c[15:8])
        8'b100?_????: begin eBand = c[12:11]; eClk = c[10:8]; eCap = c[7:4]; eMod = c[3]; eDev = c[2:0]; end
        8'b1010_????: eFreq = c[11:0];
        8'b111?_????: begin eWExp = c[12:8]; eWMant = c[7:0]; end
        8'hC0: ePm = c[7:0];
        8'hC2: eBat = c[7:0];
        8'hC8: eRate = c[7:0];
        8'hC4: begin eAutoPa = 0; eAutoSyn = 0; if (c[7:0] == 0) eAutoOsc = 0; end
        default: ;
      endcase
    end else if (n == 8 && c[7:3] == 5'b10110) begin
      ePow = c[2:0];
    end
  endtask

  task automatic csLow();
    @(negedge clk) spiCsN = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic csHigh();
    @(negedge clk) spiCsN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // tick lands on the cycle the rising edge of this bit is decoded
  task automatic shiftBit(input logic b, input bit tickAtRise);
    @(negedge clk) spiMosi = b;
    @(negedge clk) spiSck = 1'b1;
    @(negedge clk);
    @(negedge clk) if (tickAtRise) mcuClkTick = 1'b1;
    @(negedge clk) mcuClkTick = 1'b0;
    @(negedge clk) spiSck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [31:0] bits, input int n);
    csLow();
    for (int i = n - 1; i >= 0; i--) shiftBit(bits[i], 1'b0);
    csHigh();
    model(bits, n);
  endtask

  task automatic pulseTick();
    @(negedge clk) mcuClkTick = 1'b1;
    @(negedge clk) mcuClkTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    spiSck = 0; spiCsN = 1; spiMosi = 0; mcuClkTick = 0; rstN = 0;
    statusWord = 16'hB5C3; capBits = 0; capCnt = 0;
    eBand = 0; eClk = 0; eCap = 4'h8; eMod = 0; eDev = 0; eFreq = 12'h7D0;
    eRate = 0; ePow = 0; eBat = 0; eWExp = 0; eWMant = 0; ePm = 0;
    eAutoOsc = 0; eAutoSyn = 0; eAutoPa = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    checkAll("R1");
    chk("R1", "streaming", 16'(streaming), 16'd0);
    chk("R1", "miso", 16'(spiMiso), 16'd0);

    sendFrame(32'h9AB5, 16); checkAll("R2");
    sendFrame(32'hA123, 16); sendFrame(32'hC85A, 16); checkAll("R3");
    sendFrame(32'hB5, 8); checkAll("R4");
    sendFrame(32'hC03D, 16); checkAll("R5");
    sendFrame(32'hC2A9, 16); sendFrame(32'hE5C3, 16); checkAll("R6");

    // R7: wrong lengths and unknown prefixes
    sendFrame(32'h5456, 15);
    sendFrame(32'h14AC1, 17);
    sendFrame(32'hB2AA, 16);
    sendFrame(32'hA4, 8);
    checkAll("R7");
    csLow();
    for (int i = 15; i >= 0; i--) shiftBit(1'(16'hA555 >> i), 1'b0);
    repeat (4) @(negedge clk);
    chk("R7", "freq before select rise", 16'(freqWord), 16'(eFreq));
    csHigh(); model(32'hA555, 16);
    checkAll("R7");

    // R8: transmit with both auto flags
    sendFrame(32'hC0C0, 16);
    csLow();
    for (int i = 7; i >= 0; i--) shiftBit(1'(8'hC6 >> i), 1'b0);
    repeat (2) @(negedge clk);
    eAutoOsc = 1; eAutoSyn = 1; eAutoPa = 1;
    checkAll("R8");
    chk("R8", "streaming", 16'(streaming), 16'd1);
    // R9: streamed data looking like a frequency command
    capCnt = 0;
    for (int i = 15; i >= 0; i--) shiftBit(1'(16'hA3C5 >> i), 1'b0);
    csHigh();
    chk("R9", "stream count", 16'(capCnt), 16'd16);
    chk("R9", "stream bits", capBits[15:0], 16'hA3C5);
    chk("R9", "streaming after select", 16'(streaming), 16'd0);
    checkAll("R9");

    // R10: sleep with count 2
    sendFrame(32'hC402, 16); checkAll("R10");
    pulseTick(); checkAll("R10");
    pulseTick(); eAutoOsc = 0; checkAll("R10");
    sendFrame(32'hC6, 8); eAutoOsc = 1; eAutoSyn = 1; eAutoPa = 1; checkAll("R8");
    sendFrame(32'hC400, 16); checkAll("R10");
    // R8: only the oscillator/synth auto flag
    sendFrame(32'hC080, 16);
    sendFrame(32'hC6, 8); eAutoOsc = 1; eAutoSyn = 1; checkAll("R8");
    sendFrame(32'hC400, 16); checkAll("R10");

    // R11: final tick and transmit decode in one cycle
    sendFrame(32'hC0C0, 16);
    sendFrame(32'hC6, 8); eAutoOsc = 1; eAutoSyn = 1; eAutoPa = 1;
    sendFrame(32'hC401, 16);
    csLow();
    for (int i = 7; i >= 0; i--) shiftBit(1'(8'hC6 >> i), i == 0);
    repeat (2) @(negedge clk);
    eAutoSyn = 1; eAutoPa = 1;
    checkAll("R11");
    csHigh();
    pulseTick(); pulseTick();
    checkAll("R11");
    sendFrame(32'hC400, 16); checkAll("R10");

    // R12: status read
    csLow();
    for (int k = 0; k < 16; k++) begin
      if (k == 0) chk("R12", "miso before read", 16'(spiMiso), 16'd0);
      if (k >= 8) chk("R12", "status bit", 16'(spiMiso), 16'(statusWord[23 - k]));
      shiftBit(1'b0, 1'b0);
    end
    csHigh();
    chk("R12", "miso after select", 16'(spiMiso), 16'd0);
    checkAll("R12");

    // random register traffic, R2..R7
    void'($urandom(32'd20240611));
    for (int it = 0; it < 40; it++) begin
      int kind; logic [15:0] p;
      kind = $urandom_range(0, 8);
      p = 16'($urandom);
      case (kind)
        0: sendFrame({16'd0, 3'b100, p[12:0]}, 16);
        1: sendFrame({16'd0, 4'hA, p[11:0]}, 16);
        2: sendFrame({16'd0, 8'hC0, p[7:0]}, 16);
        3: sendFrame({16'd0, 8'hC8, p[7:0]}, 16);
        4: sendFrame({16'd0, 8'hC2, p[7:0]}, 16);
        5: sendFrame({16'd0, 3'b111, p[12:0]}, 16);
        6: sendFrame({24'd0, 5'b10110, p[2:0]}, 8);
        7: sendFrame({15'd0, 4'hA, p[12:0]}, 17);
        default: sendFrame({20'd0, 4'hA, p[7:0]}, 12);
      endcase
      checkAll(kind == 0 ? "R2" : kind == 1 || kind == 3 ? "R3" : kind == 2 ? "R5" :
               kind == 4 || kind == 5 ? "R6" : kind == 6 ? "R4" : "R7");
    end

    done = 1;
    finishRun();
  end
endmodule